// File: doc/BRIEF.md
# Modem Line Status Register

This block watches four incoming modem handshake lines: carrier present, ring, peer ready and clear-to-send. It presents them as one 8-bit status byte. Each line first passes through a two-flop synchronizer. The synchronized levels appear in the upper nibble. The lower nibble holds one sticky change flag per line.

Three of the flags latch on any change of level. The ring flag latches only when the ring line goes from low to high. A one-cycle read strobe stands for a read of the byte, and it clears all four flags on the next clock edge. A change that is detected in the same cycle as the strobe still sets its flag, so no event is lost.

Interrupt generation and bus decoding sit outside this block and consume the byte.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: Bits 7, 6, 5 and 4 carry the synchronized levels of carrier, ring, peer ready and clear-to-send. An input change made between edges is visible on the second clock edge after it, and not on the first.
- R3: Bit 3 sets on the clock edge after the carrier level bit changes, in either direction. Without such a change, bit 3 does not set.
- R4: Bit 2 sets on the clock edge after the ring level bit rises from 0 to 1. A fall of the ring level leaves bit 2 clear.
- R5: Bit 1 sets after any change of the peer-ready level. Bit 0 sets after any change of the clear-to-send level.
- R6: A read strobe high at a clock edge clears bits 3 to 0 at that edge, unless a new change is detected at the same edge.
- R7: A change detected at the same edge as a read strobe leaves its flag set after that edge.
- R8: Read strobes never alter bits 7 to 4.
- R9: Without a read, a set flag stays set, even if its line returns to its earlier level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierIn | input | 1 | Raw carrier-present line |
| ringIn | input | 1 | Raw ring line |
| readyIn | input | 1 | Raw peer-ready line |
| ctsIn | input | 1 | Raw clear-to-send line |
| rdStrobe | input | 1 | One-cycle read of the status byte, which clears the change flags |
| status | output | 8 | Line levels in [7:4], sticky change flags in [3:0] |

## Verification
A wrong synchronizer depth shows up as a level bit that appears one edge early or late. A stale previous-level register shows up as a flag that sets on the wrong edge, or that never sets. Both faults are visible at the port within three edges of the input change. A clear that wins over a same-edge change drops a flag, and that is visible right after the colliding read. A ring flag that reacts to falling edges appears one edge after the ring level bit drops.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;

  // Number of modem lines watched; the byte layout relies on four.
  localparam int LINE_COUNT = 4;

  // Line slots inside a nibble: the flag and level nibbles share this order.
  localparam int SLOT_CARRIER = 3;
  localparam int SLOT_RING    = 2;
  localparam int SLOT_READY   = 1;
  localparam int SLOT_CTS     = 0;

  typedef enum logic {
    DETECT_ANY  = 1'b0,
    DETECT_RISE = 1'b1
  } detectMode_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic [LINE_COUNT-1:0] setFlag;
    logic                  clearAll;
  } flagStrobe_t;

endpackage

// File: rtl/msr_datapath.sv
module msr_datapath
  import modem_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] lineRaw,
  input  flagStrobe_t           strobes,
  output logic [LINE_COUNT-1:0] syncLevel,
  output logic [LINE_COUNT-1:0] prevLevel,
  output logic [LINE_COUNT-1:0] flags
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain [LINE_COUNT];

  for (genvar lineIdx = 0; lineIdx < LINE_COUNT; lineIdx++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain[lineIdx] <= '0;
      end else begin
        syncChain[lineIdx] <= {syncChain[lineIdx][SYNC_STAGES-2:0], lineRaw[lineIdx]};
      end
    end
    assign syncLevel[lineIdx] = syncChain[lineIdx][LAST_STAGE];
  end

  // Level seen at the previous edge, used by the change detectors.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
    end else begin
      prevLevel <= syncLevel;
    end
  end

  // A set wins over a clear, so no change that collides with a read is lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~{LINE_COUNT{strobes.clearAll}}) | strobes.setFlag;
    end
  end

endmodule

// File: rtl/msr_control.sv
module msr_control
  import modem_status_pkg::*;
#(
  parameter logic [LINE_COUNT-1:0] RISE_ONLY_MASK = 4'b0100
) (
  input  logic [LINE_COUNT-1:0] syncLevel,
  input  logic [LINE_COUNT-1:0] prevLevel,
  input  logic                  rdStrobe,
  output flagStrobe_t           strobes
);

  for (genvar lineIdx = 0; lineIdx < LINE_COUNT; lineIdx++) begin : gDetect
    localparam detectMode_t MODE = RISE_ONLY_MASK[lineIdx] ? DETECT_RISE : DETECT_ANY;
    if (MODE == DETECT_RISE) begin : gRise
      assign strobes.setFlag[lineIdx] = syncLevel[lineIdx] & ~prevLevel[lineIdx];
    end else begin : gAny
      assign strobes.setFlag[lineIdx] = syncLevel[lineIdx] ^ prevLevel[lineIdx];
    end
  end

  assign strobes.clearAll = rdStrobe;

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierIn,
  input  logic       ringIn,
  input  logic       readyIn,
  input  logic       ctsIn,
  input  logic       rdStrobe,
  output logic [7:0] status
);

  localparam logic [LINE_COUNT-1:0] RING_MASK = LINE_COUNT'(1) << SLOT_RING;

  logic [LINE_COUNT-1:0] lineRaw;
  logic [LINE_COUNT-1:0] syncLevel;
  logic [LINE_COUNT-1:0] prevLevel;
  logic [LINE_COUNT-1:0] flags;
  flagStrobe_t           strobes;

  always_comb begin
    lineRaw               = '0;
    lineRaw[SLOT_CARRIER] = carrierIn;
    lineRaw[SLOT_RING]    = ringIn;
    lineRaw[SLOT_READY]   = readyIn;
    lineRaw[SLOT_CTS]     = ctsIn;
  end

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .lineRaw  (lineRaw),
    .strobes  (strobes),
    .syncLevel(syncLevel),
    .prevLevel(prevLevel),
    .flags    (flags)
  );

  msr_control #(.RISE_ONLY_MASK(RING_MASK)) i_control (
    .syncLevel(syncLevel),
    .prevLevel(prevLevel),
    .rdStrobe (rdStrobe),
    .strobes  (strobes)
  );

  assign status = {syncLevel, flags};

endmodule

// File: rtl/modem_status_checker.sv
module modem_status_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdStrobe,
  input logic [7:0] status
);

  assert_carrier_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (status[7] != $past(status[7])) |=> status[3]);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!status[3] && status[7] == $past(status[7])) |=> !status[3]);

  assert_ring_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (status[6] && !$past(status[6])) |=> status[2]);

  assert_ring_fall_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!status[6] && $past(status[6]) && rdStrobe) |=> !status[2]);

  assert_ready_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (status[5] != $past(status[5])) |=> status[1]);

  assert_cts_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (status[4] != $past(status[4])) |=> status[0]);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && status[7:4] == $past(status[7:4])) |=> (status[3:0] == 4'h0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0])));

endmodule

bind modem_status_reg modem_status_checker i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .rdStrobe(rdStrobe),
  .status  (status)
);

// File: tb/test_modem_status_reg.sv
module test_modem_status_reg;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 5000;

  typedef struct {
    int         due;
    logic [7:0] value;
    string      tag;
  } expectItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       carrierIn = 1'b0;
  logic       ringIn = 1'b0;
  logic       readyIn = 1'b0;
  logic       ctsIn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] status;

  int          cycleCount = 0;
  int          compared = 0;
  int          mismatched = 0;
  expectItem_t expectQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycleCount <= cycleCount + 1;

  modem_status_reg i_modem_status_reg (
    .clk      (clk),
    .rstN     (rstN),
    .carrierIn(carrierIn),
    .ringIn   (ringIn),
    .readyIn  (readyIn),
    .ctsIn    (ctsIn),
    .rdStrobe (rdStrobe),
    .status   (status)
  );

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    while (expectQ.size() > 0 && expectQ[0].due <= cycleCount) begin
      expectItem_t item;
      item = expectQ.pop_front();
      compared++;
      if (status !== item.value) begin
        mismatched++;
        $display("FAIL %s: status actual 0x%02h expected 0x%02h at cycle %0d",
                 item.tag, status, item.value, cycleCount);
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectAt(input int offset, input logic [7:0] value, input string tag);
    expectItem_t item;
    item.due = cycleCount + offset;
    item.value = value;
    item.tag = tag;
    expectQ.push_back(item);
  endtask

  task automatic readOnce();
    rdStrobe = 1'b1;
    step();
    rdStrobe = 1'b0;
  endtask

  task automatic runStimulus();
    step(3);
    rstN = 1'b1;
    expectAt(1, 8'h00, "R1 reset value");
    step(2);

    // Carrier rises: level at the second edge, flag at the third
    carrierIn = 1'b1;
    expectAt(1, 8'h00, "R2 not yet through synchronizer");
    expectAt(2, 8'h80, "R2 carrier level");
    expectAt(3, 8'h88, "R3 carrier change flag");
    step(4);
    expectAt(1, 8'h80, "R6 read clears flag, R8 level kept");
    readOnce();
    step(1);

    // Ring rises, then falls
    ringIn = 1'b1;
    expectAt(2, 8'hC0, "R2 ring level");
    expectAt(3, 8'hC4, "R4 ring rise flag");
    step(4);
    expectAt(1, 8'hC0, "R6 ring flag cleared");
    readOnce();
    ringIn = 1'b0;
    expectAt(2, 8'h80, "R2 ring level low");
    expectAt(3, 8'h80, "R4 ring fall ignored");
    expectAt(5, 8'h80, "R4 ring fall still ignored");
    step(6);

    // Peer ready and clear-to-send together
    readyIn = 1'b1;
    ctsIn = 1'b1;
    expectAt(2, 8'hB0, "R2 ready and cts levels");
    expectAt(3, 8'hB3, "R5 ready and cts flags");
    step(4);
    ctsIn = 1'b0;
    expectAt(2, 8'hA3, "R9 cts flag sticky on return");
    expectAt(3, 8'hA3, "R9 flags held without read");
    step(4);
    expectAt(1, 8'hA0, "R6 both flags cleared, R8 levels kept");
    readOnce();
    step(1);

    // Carrier falls with a read landing on the detection edge
    carrierIn = 1'b0;
    expectAt(2, 8'h20, "R2 carrier level low");
    expectAt(3, 8'h28, "R7 change survives coincident read");
    expectAt(4, 8'h28, "R9 flag held after collision");
    step(2);
    readOnce();
    step(1);
    expectAt(1, 8'h20, "R6 flag cleared by later read");
    readOnce();
    step(1);

    // Several lines rise, then a long read
    carrierIn = 1'b1;
    ringIn = 1'b1;
    ctsIn = 1'b1;
    expectAt(2, 8'hF0, "R2 all levels high");
    expectAt(3, 8'hFD, "R5 carrier ring cts flags");
    step(4);
    expectAt(1, 8'hF0, "R8 read keeps levels");
    expectAt(2, 8'hF0, "R8 held read keeps levels");
    rdStrobe = 1'b1;
    step(2);
    rdStrobe = 1'b0;
    step(3);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    fork
      runStimulus();
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    while (expectQ.size() > 0) begin
      expectItem_t item;
      item = expectQ.pop_front();
      compared++;
      mismatched++;
      $display("FAIL %s: actual unchecked expected 0x%02h", item.tag, item.value);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule